// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Operand Wakeup

This block holds dispatched instructions until their source operands are available, then sends them to the execute stage. Each cycle it accepts at most one dispatched instruction. The instruction carries four things: a sequence number, a class (integer, floating point or branch), up to two source physical registers and an optional destination register. A one-bit-per-register readiness map tells the queue whether a source is already produced. A completion broadcast names a produced register, sets its bit and wakes every waiting entry that needs it.

Every queue slot runs a four-state machine:

- FREE --alloc--> WAIT, when some valid source is still pending.
- FREE --alloc--> READY, when all sources are ready.
- WAIT --wake--> READY, once the last pending source is broadcast.
- READY --grant--> ISSUED.
- ISSUED --release--> FREE, on the next edge.
- Any non-FREE state --kill--> FREE, when a squash names a sequence number older than the slot's own.

Selection is oldest first. It is done separately for each class, and each class has its own per-cycle limit. The class winners then share a total limit, again oldest first. A squash removes every younger entry in one edge, and in that cycle it blocks both issue and insertion. The readiness map is used for wakeup only.

Top module: `iq_issue_queue`

## Requirements
- R1: `free_cnt` equals the number of FREE slots and resets to DEPTH. `full` is high exactly when `free_cnt` is 0. At most one slot is allocated per cycle.
- R2: Take an instruction with no pending source, dispatched at clock edge N. It appears on an issue lane between edges N and N+1.
- R3: Class codes on `disp_cls` are 0 for integer, 1 for floating point and 2 for branch; code 3 is handled as integer. At most INT_W integer, FP_W floating-point and BR_W branch instructions issue in one cycle.
- R4: No more than TOT_W instructions issue in one cycle. When the class winners exceed TOT_W, the oldest of them issue.
- R5: Within a class, the oldest ready entries win. Valid lanes are packed from lane 0 upward, and they are ordered oldest first.
- R6: A dispatch with a destination marks that register pending. A consumer of the register waits in WAIT until every pending source has been broadcast on `wb_valid`/`wb_reg`. It issues in the cycle after the last broadcast.
- R7: A broadcast in the same cycle as a dispatch that reads the same register marks that operand ready at insertion.
- R8: A squash on `flush_valid` frees, at the next edge, every occupied slot whose sequence number is younger than `flush_seq`. The slot that equals `flush_seq`, and older slots, stay.
- R9: While `flush_valid` is high, `iss_valid` is 0 and the dispatch input is ignored.
- R10: An issued slot is held for one cycle after the issue cycle, then returned to FREE.
- R11: Sequence numbers wrap. Number a is older than b when the top bit of (a - b) modulo 2^SEQ_W is 1.
- R12: A dispatch while `full` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_cls | input | 2 | Class: 0 integer, 1 floating point, 2 branch |
| disp_src0_vld | input | 1 | Source 0 present |
| disp_src0 | input | PR_W | Source 0 physical register |
| disp_src1_vld | input | 1 | Source 1 present |
| disp_src1 | input | PR_W | Source 1 physical register |
| disp_dst_vld | input | 1 | Destination present |
| disp_dst | input | PR_W | Destination physical register |
| wb_valid | input | 1 | Completion broadcast |
| wb_reg | input | PR_W | Register produced by the completion |
| flush_valid | input | 1 | Squash request |
| flush_seq | input | SEQ_W | Entries younger than this are removed |
| iss_valid | output | TOT_W | Per-lane issue valid |
| iss_seq | output | TOT_W*SEQ_W | Per-lane sequence numbers |
| iss_cls | output | TOT_W*2 | Per-lane class codes |
| iss_dst | output | TOT_W*PR_W | Per-lane destination registers |
| free_cnt | output | CNT_W | Number of FREE slots |
| full | output | 1 | No FREE slot |

## Verification
The hardest situation to reach from the ports has three parts at once: several classes ready in the same cycle, with enough winners that the total cap cuts them. Only one instruction enters per cycle, so the bench first makes a register pending through a producer that carries it as destination. It then parks a chosen mix of floating-point, branch and integer consumers on that register, and releases them all with a single broadcast. Sweeping every mix up to the queue depth covers each per-class limit and the total cap. A second hard case is a squash landing in the very cycle an older entry would issue. The bench reaches it by giving the ready entry a smaller sequence number than the parked ones dispatched before it.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_FP  = 2'd1,
        CLS_BR  = 2'd2,
        CLS_RSV = 2'd3
    } iq_cls_e;

    typedef enum logic [1:0] {
        ENT_FREE   = 2'd0,
        ENT_WAIT   = 2'd1,
        ENT_READY  = 2'd2,
        ENT_ISSUED = 2'd3
    } ent_state_e;

endpackage

// File: rtl/iq_regmap.sv
module iq_regmap #(
    parameter int NPREG = 16,
    parameter int PR_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_vld,
    input  logic [PR_W-1:0]  set_reg,
    input  logic             clr_vld,
    input  logic [PR_W-1:0]  clr_reg,
    output logic [NPREG-1:0] rdy_q
);

    // A new producer's pending mark wins over a same-cycle broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '1;
        end else begin
            if (set_vld) rdy_q[set_reg] <= 1'b1;
            if (clr_vld) rdy_q[clr_reg] <= 1'b0;
        end
    end

endmodule

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
#(
    parameter int SEQ_W = 8,
    parameter int PR_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [SEQ_W-1:0] in_seq,
    input  iq_cls_e          in_cls,
    input  logic [PR_W-1:0]  in_src0,
    input  logic [PR_W-1:0]  in_src1,
    input  logic [1:0]       in_src_rdy,
    input  logic [PR_W-1:0]  in_dst,
    input  logic             wb_valid,
    input  logic [PR_W-1:0]  wb_reg,
    input  logic             flush_valid,
    input  logic [SEQ_W-1:0] flush_seq,
    input  logic             grant,
    output ent_state_e       st_q,
    output logic [SEQ_W-1:0] seq_q,
    output iq_cls_e          cls_q,
    output logic [PR_W-1:0]  dst_q
);

    ent_state_e      st_d;
    logic [PR_W-1:0] src0_q, src1_q;
    logic [1:0]      rdy_q, wake, rdy_nxt;
    logic [SEQ_W-1:0] age_diff;
    logic            kill;

    assign wake[0]  = wb_valid && (wb_reg == src0_q);
    assign wake[1]  = wb_valid && (wb_reg == src1_q);
    assign rdy_nxt  = rdy_q | wake;
    assign age_diff = seq_q - flush_seq;
    assign kill     = flush_valid && (st_q != ENT_FREE)
                      && !age_diff[SEQ_W-1] && (age_diff != '0);

    always_comb begin
        st_d = st_q;
        if (kill) begin
            st_d = ENT_FREE;
        end else begin
            unique case (st_q)
                ENT_FREE:   if (alloc) st_d = (&in_src_rdy) ? ENT_READY : ENT_WAIT;
                ENT_WAIT:   if (&rdy_nxt) st_d = ENT_READY;
                ENT_READY:  if (grant) st_d = ENT_ISSUED;
                ENT_ISSUED: st_d = ENT_FREE;
                default:    st_d = ENT_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ENT_FREE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= '0;
            cls_q  <= CLS_INT;
            src0_q <= '0;
            src1_q <= '0;
            rdy_q  <= '1;
            dst_q  <= '0;
        end else if (alloc && st_q == ENT_FREE) begin
            seq_q  <= in_seq;
            cls_q  <= in_cls;
            src0_q <= in_src0;
            src1_q <= in_src1;
            rdy_q  <= in_src_rdy;
            dst_q  <= in_dst;
        end else begin
            rdy_q  <= rdy_nxt;
        end
    end

endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 8,
    parameter int PR_W  = 4,
    parameter int INT_W = 2,
    parameter int FP_W  = 1,
    parameter int BR_W  = 1,
    parameter int TOT_W = 3
) (
    input  logic [DEPTH-1:0] rdy,
    input  iq_cls_e          cls      [DEPTH],
    input  logic [SEQ_W-1:0] seq      [DEPTH],
    input  logic [PR_W-1:0]  dst      [DEPTH],
    input  logic             block,
    output logic [DEPTH-1:0] grant,
    output logic [TOT_W-1:0] lane_vld,
    output logic [SEQ_W-1:0] lane_seq [TOT_W],
    output logic [1:0]       lane_cls [TOT_W],
    output logic [PR_W-1:0]  lane_dst [TOT_W]
);

    function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction

    function automatic iq_cls_e grp(input iq_cls_e c);
        return (c == CLS_RSV) ? CLS_INT : c;
    endfunction

    function automatic int limit(input iq_cls_e c);
        case (grp(c))
            CLS_FP:  return FP_W;
            CLS_BR:  return BR_W;
            default: return INT_W;
        endcase
    endfunction

    int               cls_rank [DEPTH];
    int               all_rank [DEPTH];
    logic [DEPTH-1:0] cls_ok;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cls_rank[i] = 0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && rdy[j] && grp(cls[j]) == grp(cls[i]) && older(seq[j], seq[i]))
                    cls_rank[i] = cls_rank[i] + 1;
            end
            cls_ok[i] = rdy[i] && !block && (cls_rank[i] < limit(cls[i]));
        end
        for (int i = 0; i < DEPTH; i++) begin
            all_rank[i] = 0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && cls_ok[j] && older(seq[j], seq[i]))
                    all_rank[i] = all_rank[i] + 1;
            end
            grant[i] = cls_ok[i] && (all_rank[i] < TOT_W);
        end
    end

    always_comb begin
        for (int k = 0; k < TOT_W; k++) begin
            lane_vld[k] = 1'b0;
            lane_seq[k] = '0;
            lane_cls[k] = '0;
            lane_dst[k] = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (grant[i] && all_rank[i] == k) begin
                    lane_vld[k] = 1'b1;
                    lane_seq[k] = seq[i];
                    lane_cls[k] = cls[i];
                    lane_dst[k] = dst[i];
                end
            end
        end
    end

endmodule

// File: rtl/iq_issue_queue.sv
module iq_issue_queue
    import iq_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int NPREG = 16,
    parameter  int SEQ_W = 8,
    parameter  int INT_W = 2,
    parameter  int FP_W  = 1,
    parameter  int BR_W  = 1,
    parameter  int TOT_W = 3,
    localparam int PR_W  = $clog2(NPREG),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_valid,
    input  logic [SEQ_W-1:0]       disp_seq,
    input  logic [1:0]             disp_cls,
    input  logic                   disp_src0_vld,
    input  logic [PR_W-1:0]        disp_src0,
    input  logic                   disp_src1_vld,
    input  logic [PR_W-1:0]        disp_src1,
    input  logic                   disp_dst_vld,
    input  logic [PR_W-1:0]        disp_dst,
    input  logic                   wb_valid,
    input  logic [PR_W-1:0]        wb_reg,
    input  logic                   flush_valid,
    input  logic [SEQ_W-1:0]       flush_seq,
    output logic [TOT_W-1:0]       iss_valid,
    output logic [TOT_W*SEQ_W-1:0] iss_seq,
    output logic [TOT_W*2-1:0]     iss_cls,
    output logic [TOT_W*PR_W-1:0]  iss_dst,
    output logic [CNT_W-1:0]       free_cnt,
    output logic                   full
);

    ent_state_e       st    [DEPTH];
    logic [SEQ_W-1:0] seq_a [DEPTH];
    iq_cls_e          cls_a [DEPTH];
    logic [PR_W-1:0]  dst_a [DEPTH];
    logic [DEPTH-1:0] free_v, ready_v, alloc_v, grant_v;
    logic [NPREG-1:0] reg_rdy;
    logic [1:0]       src_rdy_in;
    logic             accept, found;
    logic [SEQ_W-1:0] lane_seq [TOT_W];
    logic [1:0]       lane_cls [TOT_W];
    logic [PR_W-1:0]  lane_dst [TOT_W];

    assign accept = disp_valid && !full && !flush_valid;

    assign src_rdy_in[0] = !disp_src0_vld || reg_rdy[disp_src0] || (wb_valid && wb_reg == disp_src0);
    assign src_rdy_in[1] = !disp_src1_vld || reg_rdy[disp_src1] || (wb_valid && wb_reg == disp_src1);

    always_comb begin
        free_cnt = '0;
        alloc_v  = '0;
        found    = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            free_cnt = free_cnt + CNT_W'(free_v[i]);
            if (free_v[i] && !found) begin
                alloc_v[i] = accept;
                found      = 1'b1;
            end
        end
        full = (free_cnt == '0);
    end

    iq_regmap #(.NPREG(NPREG), .PR_W(PR_W)) u_regmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vld (wb_valid),
        .set_reg (wb_reg),
        .clr_vld (accept && disp_dst_vld),
        .clr_reg (disp_dst),
        .rdy_q   (reg_rdy)
    );

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        iq_entry #(.SEQ_W(SEQ_W), .PR_W(PR_W)) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (alloc_v[e]),
            .in_seq      (disp_seq),
            .in_cls      (iq_cls_e'(disp_cls)),
            .in_src0     (disp_src0),
            .in_src1     (disp_src1),
            .in_src_rdy  (src_rdy_in),
            .in_dst      (disp_dst),
            .wb_valid    (wb_valid),
            .wb_reg      (wb_reg),
            .flush_valid (flush_valid),
            .flush_seq   (flush_seq),
            .grant       (grant_v[e]),
            .st_q        (st[e]),
            .seq_q       (seq_a[e]),
            .cls_q       (cls_a[e]),
            .dst_q       (dst_a[e])
        );
        assign free_v[e]  = (st[e] == ENT_FREE);
        assign ready_v[e] = (st[e] == ENT_READY);
    end

    iq_select #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PR_W(PR_W),
        .INT_W(INT_W), .FP_W(FP_W), .BR_W(BR_W), .TOT_W(TOT_W)
    ) u_select (
        .rdy      (ready_v),
        .cls      (cls_a),
        .seq      (seq_a),
        .dst      (dst_a),
        .block    (flush_valid),
        .grant    (grant_v),
        .lane_vld (iss_valid),
        .lane_seq (lane_seq),
        .lane_cls (lane_cls),
        .lane_dst (lane_dst)
    );

    for (genvar k = 0; k < TOT_W; k++) begin : g_lane
        assign iss_seq[k*SEQ_W +: SEQ_W] = lane_seq[k];
        assign iss_cls[k*2 +: 2]         = lane_cls[k];
        assign iss_dst[k*PR_W +: PR_W]   = lane_dst[k];
    end

endmodule

// File: rtl/iq_issue_queue_chk.sv
module iq_issue_queue_chk #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 8,
    parameter int INT_W = 2,
    parameter int FP_W  = 1,
    parameter int BR_W  = 1,
    parameter int TOT_W = 3,
    parameter int CNT_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   flush_valid,
    input logic [TOT_W-1:0]       iss_valid,
    input logic [TOT_W*SEQ_W-1:0] iss_seq,
    input logic [TOT_W*2-1:0]     iss_cls,
    input logic [CNT_W-1:0]       free_cnt
);

    int n_int, n_fp, n_br;

    always_comb begin
        n_int = 0;
        n_fp  = 0;
        n_br  = 0;
        for (int k = 0; k < TOT_W; k++) begin
            if (iss_valid[k]) begin
                if (iss_cls[k*2 +: 2] == 2'd1)      n_fp  = n_fp + 1;
                else if (iss_cls[k*2 +: 2] == 2'd2) n_br  = n_br + 1;
                else                                n_int = n_int + 1;
            end
        end
    end

    // R9
    flush_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (iss_valid == '0));

    // R3
    int_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) n_int <= INT_W);

    // R3
    fp_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) n_fp <= FP_W);

    // R3
    br_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) n_br <= BR_W);

    // R1
    one_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_valid |=> (int'(free_cnt) + 1 >= int'($past(free_cnt))));

    // R1
    free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_cnt) <= DEPTH);

    for (genvar k = 0; k < TOT_W - 1; k++) begin : g_ord
        logic [SEQ_W-1:0] gap;
        assign gap = iss_seq[k*SEQ_W +: SEQ_W] - iss_seq[(k+1)*SEQ_W +: SEQ_W];
        // R5
        lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k+1] |-> (iss_valid[k] && gap[SEQ_W-1]));
    end

endmodule

bind iq_issue_queue iq_issue_queue_chk #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .INT_W(INT_W), .FP_W(FP_W),
    .BR_W(BR_W), .TOT_W(TOT_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_valid (flush_valid),
    .iss_valid   (iss_valid),
    .iss_seq     (iss_seq),
    .iss_cls     (iss_cls),
    .free_cnt    (free_cnt)
);

// File: tb/tb_iq_issue_queue.sv
module tb_iq_issue_queue;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int SEQ_W = 8;
    localparam int PR_W  = 4;
    localparam int TOT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             disp_valid, disp_src0_vld, disp_src1_vld, disp_dst_vld;
    logic [SEQ_W-1:0] disp_seq, flush_seq;
    logic [1:0]       disp_cls;
    logic [PR_W-1:0]  disp_src0, disp_src1, disp_dst, wb_reg;
    logic             wb_valid, flush_valid;
    logic [TOT_W-1:0]       iss_valid;
    logic [TOT_W*SEQ_W-1:0] iss_seq;
    logic [TOT_W*2-1:0]     iss_cls;
    logic [TOT_W*PR_W-1:0]  iss_dst;
    logic [3:0]             free_cnt;
    logic                   full;

    int n_chk = 0;
    int n_fail = 0;
    logic [SEQ_W-1:0] seqc = 8'd200;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_issue_queue dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_seq(disp_seq), .disp_cls(disp_cls),
        .disp_src0_vld(disp_src0_vld), .disp_src0(disp_src0),
        .disp_src1_vld(disp_src1_vld), .disp_src1(disp_src1),
        .disp_dst_vld(disp_dst_vld), .disp_dst(disp_dst),
        .wb_valid(wb_valid), .wb_reg(wb_reg),
        .flush_valid(flush_valid), .flush_seq(flush_seq),
        .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_cls(iss_cls), .iss_dst(iss_dst),
        .free_cnt(free_cnt), .full(full)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lane_seq(input int k);
        return int'(iss_seq[k*SEQ_W +: SEQ_W]);
    endfunction

    task automatic clear_in();
        disp_valid = 0; disp_seq = '0; disp_cls = '0;
        disp_src0_vld = 0; disp_src0 = '0; disp_src1_vld = 0; disp_src1 = '0;
        disp_dst_vld = 0; disp_dst = '0; wb_valid = 0; wb_reg = '0;
        flush_valid = 0; flush_seq = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1 clear_in();
        #1;
    endtask

    task automatic set_disp(input int sq, input int cl, input int s0v, input int s0,
                            input int s1v, input int s1, input int dv, input int d);
        disp_valid = 1; disp_seq = SEQ_W'(sq); disp_cls = 2'(cl);
        disp_src0_vld = 1'(s0v); disp_src0 = PR_W'(s0);
        disp_src1_vld = 1'(s1v); disp_src1 = PR_W'(s1);
        disp_dst_vld = 1'(dv); disp_dst = PR_W'(d);
    endtask

    task automatic disp(input int sq, input int cl, input int s0v, input int s0,
                        input int s1v, input int s1, input int dv, input int d);
        set_disp(sq, cl, s0v, s0, s1v, s1, dv, d);
        tick();
    endtask

    task automatic make_pending(input int r);
        disp(int'(seqc), 2, 0, 0, 0, 0, 1, r);
        seqc = seqc + 1'b1;
        repeat (3) tick();
    endtask

    task automatic wake(input int r);
        wb_valid = 1; wb_reg = PR_W'(r);
        tick();
    endtask

    task automatic drain(output int issued);
        issued = 0;
        for (int c = 0; c < 40; c++) begin
            if (free_cnt == 4'(DEPTH)) break;
            issued += $countones(iss_valid);
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int got;
        logic [SEQ_W-1:0] s;
        clear_in();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 reset free_cnt", int'(free_cnt), DEPTH);
        chk("R1 reset full", int'(full), 0);
        chk("R1 reset iss_valid", int'(iss_valid), 0);

        // R2 immediate issue, R10 release one cycle after issue
        s = seqc; seqc = seqc + 1'b1;
        disp(int'(s), 0, 0, 0, 0, 0, 0, 0);
        chk("R2 issue after insert", int'(iss_valid), 1);
        chk("R2 lane0 seq", lane_seq(0), int'(s));
        chk("R1 free after insert", int'(free_cnt), DEPTH - 1);
        tick();
        chk("R10 no reissue", int'(iss_valid), 0);
        chk("R10 held one cycle", int'(free_cnt), DEPTH - 1);
        tick();
        chk("R10 released", int'(free_cnt), DEPTH);

        // R3 R4 R5 R6 sweep over class mixes
        for (int ni = 0; ni <= 4; ni++) begin
            for (int nf = 0; nf <= 2; nf++) begin
                for (int nb = 0; nb <= 2; nb++) begin
                    logic [SEQ_W-1:0] base;
                    int exp_seq [4];
                    int ne, n;
                    make_pending(5);
                    base = seqc;
                    for (int f = 0; f < nf; f++) begin disp(int'(seqc), 1, 1, 5, 0, 0, 0, 0); seqc = seqc + 1'b1; end
                    for (int b = 0; b < nb; b++) begin disp(int'(seqc), 2, 1, 5, 0, 0, 0, 0); seqc = seqc + 1'b1; end
                    for (int i = 0; i < ni; i++) begin disp(int'(seqc), 0, 0, 0, 1, 5, 0, 0); seqc = seqc + 1'b1; end
                    n = ni + nf + nb;
                    chk("R1 sweep occupancy", int'(free_cnt), DEPTH - n);
                    chk("R6 parked before wake", int'(iss_valid), 0);
                    ne = 0;
                    if (nf > 0) begin exp_seq[ne] = int'(base); ne++; end
                    if (nb > 0) begin exp_seq[ne] = int'(SEQ_W'(base + nf)); ne++; end
                    for (int i = 0; i < ni && i < 2; i++) begin
                        exp_seq[ne] = int'(SEQ_W'(base + nf + nb + i)); ne++;
                    end
                    if (ne > TOT_W) ne = TOT_W;
                    wake(5);
                    chk("R3 R4 issue count", $countones(iss_valid), ne);
                    for (int k = 0; k < ne; k++)
                        chk("R5 lane seq", lane_seq(k), exp_seq[k]);
                    drain(got);
                    chk("R6 all woken issue", got, n);
                    chk("R1 drained", int'(free_cnt), DEPTH);
                end
            end
        end

        // R7 same-cycle bypass
        make_pending(6);
        s = seqc; seqc = seqc + 1'b1;
        set_disp(int'(s), 0, 1, 6, 0, 0, 0, 0);
        wb_valid = 1; wb_reg = 4'd6;
        tick();
        chk("R7 bypass issue", int'(iss_valid), 1);
        chk("R7 bypass seq", lane_seq(0), int'(s));
        drain(got);

        // R6 two sources
        make_pending(8);
        make_pending(9);
        s = seqc; seqc = seqc + 1'b1;
        disp(int'(s), 0, 1, 8, 1, 9, 0, 0);
        wake(8);
        chk("R6 one source left", int'(iss_valid), 0);
        wake(9);
        chk("R6 both sources ready", int'(iss_valid), 1);
        chk("R6 seq", lane_seq(0), int'(s));
        drain(got);

        // R8 R9 squash
        make_pending(10);
        s = seqc; seqc = seqc + 3'd6;
        for (int w = 1; w <= 4; w++) disp(int'(SEQ_W'(s + w)), 0, 1, 10, 0, 0, 0, 0);
        disp(int'(s), 0, 0, 0, 0, 0, 0, 0);
        chk("R8 before squash", int'(free_cnt), DEPTH - 5);
        flush_valid = 1; flush_seq = s + 2'd2;
        set_disp(int'(SEQ_W'(s + 5)), 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk("R9 no issue during squash", int'(iss_valid), 0);
        tick();
        chk("R8 R9 squash freed younger, dispatch ignored", int'(free_cnt), DEPTH - 3);
        chk("R9 issue resumes", int'(iss_valid), 1);
        chk("R9 resumed seq", lane_seq(0), int'(s));
        tick();
        wake(10);
        chk("R8 survivors issue", $countones(iss_valid), 2);
        chk("R8 survivor lane0", lane_seq(0), int'(SEQ_W'(s + 1)));
        chk("R8 survivor lane1", lane_seq(1), int'(SEQ_W'(s + 2)));
        drain(got);
        chk("R8 nothing else left", got, 2);

        // R12 full
        make_pending(11);
        s = seqc; seqc = seqc + 4'd9;
        for (int w = 0; w < DEPTH; w++) disp(int'(SEQ_W'(s + w)), 0, 1, 11, 0, 0, 0, 0);
        chk("R1 full flag", int'(full), 1);
        chk("R1 full count", int'(free_cnt), 0);
        disp(int'(SEQ_W'(s + 8)), 0, 0, 0, 0, 0, 0, 0);
        chk("R12 rejected dispatch no issue", int'(iss_valid), 0);
        chk("R12 still full", int'(free_cnt), 0);
        wake(11);
        chk("R12 oldest first after wake", lane_seq(0), int'(s));
        drain(got);
        chk("R12 only queued entries issue", got, DEPTH);

        // R11 wrap-safe ordering
        make_pending(12);
        disp(1, 0, 1, 12, 0, 0, 0, 0);
        disp(254, 0, 1, 12, 0, 0, 0, 0);
        disp(253, 0, 1, 12, 0, 0, 0, 0);
        wake(12);
        chk("R11 wrap count", $countones(iss_valid), 2);
        chk("R11 wrap lane0", lane_seq(0), 253);
        chk("R11 wrap lane1", lane_seq(1), 254);
        tick();
        chk("R11 wrapped youngest next", lane_seq(0), 1);
        drain(got);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule